// File: doc/BRIEF.md
# Fan Tachometer Period Monitor

This block measures how long a fan takes per tachometer pulse. A free-running timebase produces a base tick. A prescaler divides that tick by 2, 4, 8 or 16 to make the counting rate. An 8-bit counter then counts at that rate between successive rising edges of the tachometer input. At each edge the count is captured into a period register and the counter starts again. A larger captured value therefore means a slower fan.

If the counter reaches full scale before the next edge arrives, the fan is treated as stalled or badly worn. The counter saturates and the period register shows full scale. When fault reporting is enabled, a sticky active-low fault bit drops and an interrupt request rises. Both stay in that state until a clear strobe arrives. Host access to the block is handled outside it.

Top module: `fan_tach_monitor`

## Requirements
- R1: After reset, `period_q` is 0, `fault_n` is 1 and `irq` is 0.
- R2: On each synchronized rising edge of `tach_in`, `period_q` takes the number of counting steps that occurred since the previous rising edge, and counting restarts from zero. For edges exactly N step intervals apart, the value is exactly N.
- R3: One counting step takes 2, 4, 8 or 16 base ticks for `div_sel` = 0, 1, 2 or 3 respectively.
- R4: One base tick occurs every `TICK_CYCLES` clock cycles, so one step lasts `TICK_CYCLES * (2 << div_sel)` clocks.
- R5: When the count reaches 255 before a new edge, the counter saturates and `period_q` reads 255 immediately. It holds 255 until an edge latches a new value. A window of 254 steps causes no overflow.
- R6: With `fault_en` = 1, an overflow drives `fault_n` low. It stays low until `fault_clr` is pulsed.
- R7: With `fault_en` = 0, an overflow leaves `fault_n` high. Enabling later does not report that earlier overflow.
- R8: `irq` is high exactly while a recorded fault is present and `fault_en` is 1.
- R9: A one-cycle `fault_clr` pulse returns `fault_n` to 1 and `irq` to 0.
- R10: Any change of `div_sel` restarts the prescaler. If `div_sel` changes more often than one step length, the counter does not advance.
- R11: `tach_in` passes through two synchronizing flops. `period_q` changes on the third rising clock edge after `tach_in` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tach_in | input | 1 | Asynchronous tachometer pulse input |
| div_sel | input | 2 | Prescale select: step = 2, 4, 8 or 16 base ticks |
| fault_en | input | 1 | Enables fault recording and interrupt |
| fault_clr | input | 1 | One-cycle strobe that clears a recorded fault |
| period_q | output | CNT_W (8) | Last captured period count; full scale on overflow |
| fault_n | output | 1 | Active-low sticky fault flag |
| irq | output | 1 | Interrupt request for an enabled, recorded fault |

## Verification
The bench runs a sweep over every divisor and several periods, from 1 step up to 254 steps. Each edge spacing is an exact multiple of the step length. A counter that dropped the step falling on the edge cycle would read one low, and a wrong prescale ratio would scale every result. Stall tests check that a counter that wrapped instead of saturating would show a small value and no fault. They also check that a non-sticky or unmasked fault would show up in `fault_n` after the clear or with the enable off. Rapid toggling of `div_sel` exposes a prescaler that fails to restart, because the counter would advance. A single-edge latency probe catches one synchronizer flop too many or too few.

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor #(
  parameter int TICK_CYCLES = 1000,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tach_in,
  input  logic [1:0]       div_sel,
  input  logic             fault_en,
  input  logic             fault_clr,
  output logic [CNT_W-1:0] period_q,
  output logic             fault_n,
  output logic             irq
);
  localparam int TW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] MAX = '1;

  logic [TW-1:0]    tick_cnt;
  logic [3:0]       pre_cnt;
  logic [1:0]       sel_q;
  logic [2:0]       sync;
  logic [CNT_W-1:0] cnt;
  logic             flag;

  wire        base_tick = (tick_cnt == TW'(TICK_CYCLES - 1));
  wire [3:0]  pre_last  = 4'((5'd2 << div_sel) - 5'd1);
  wire        sel_chg   = (div_sel != sel_q);
  wire        adv       = base_tick && !sel_chg && (pre_cnt == pre_last);
  wire        rise      = sync[1] && !sync[2];
  wire        ovf_evt   = adv && !rise && (cnt == MAX - 1'b1);

  assign fault_n = !flag;
  assign irq     = flag && fault_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      pre_cnt  <= '0;
      sel_q    <= div_sel;
      sync     <= '0;
    end else begin
      tick_cnt <= base_tick ? '0 : tick_cnt + 1'b1;
      sel_q    <= div_sel;
      sync     <= {sync[1:0], tach_in};
      if (sel_chg)
        pre_cnt <= '0;
      else if (base_tick)
        pre_cnt <= (pre_cnt == pre_last) ? 4'd0 : pre_cnt + 4'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      period_q <= '0;
      flag     <= 1'b0;
    end else begin
      if (rise)
        cnt <= CNT_W'(adv);
      else if (adv && cnt != MAX)
        cnt <= cnt + 1'b1;

      if (rise)
        period_q <= cnt;
      else if (ovf_evt)
        period_q <= MAX;

      if (ovf_evt && fault_en)
        flag <= 1'b1;
      else if (fault_clr)
        flag <= 1'b0;
    end
  end

  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (cnt <= CNT_W'(1)));
  assert_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAX && !rise) |=> (cnt == MAX));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (period_q != $past(period_q)) |-> ($past(rise) || period_q == MAX));
  assert_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_n) |-> $past(fault_en));
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_clr && !ovf_evt) |=> fault_n);
  assert_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !fault_n);
endmodule

// File: tb/fan_tach_monitor_tb.sv
module fan_tach_monitor_tb;
  localparam int TICK = 3;
  logic clk = 0, rst_n = 0, tach_in = 0, fault_en = 1, fault_clr = 0;
  logic [1:0] div_sel = 0;
  logic [7:0] period_q;
  logic fault_n, irq;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fan_tach_monitor #(.TICK_CYCLES(TICK), .CNT_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .div_sel(div_sel),
    .fault_en(fault_en), .fault_clr(fault_clr),
    .period_q(period_q), .fault_n(fault_n), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int p);
    tach_in = 1; cyc(p / 2);
    tach_in = 0; cyc(p - p / 2);
  endtask

  function automatic int step(input int sel);
    return TICK * (2 << sel);
  endfunction

  initial begin
    int ks[4] = '{1, 3, 100, 254};
    cyc(3);
    chk("R1 period", period_q, 0);
    chk("R1 fault_n", fault_n, 1);
    chk("R1 irq", irq, 0);
    rst_n = 1;
    for (int s = 0; s < 4; s++) begin
      div_sel = 2'(s);
      for (int j = 0; j < 4; j++) begin
        pulse(ks[j] * step(s));
        pulse(ks[j] * step(s));
        chk($sformatf("R2 R3 R4 sel=%0d", s), period_q, ks[j]);
      end
    end
    chk("R5 no fault at 254", fault_n, 1);

    div_sel = 0;
    pulse(4 * step(0)); pulse(9 * step(0));
    tach_in = 1;
    cyc(1); @(posedge clk); #1;
    chk("R11 before third edge", period_q, 4);
    @(posedge clk); #1;
    chk("R11 third edge", period_q, 9);
    @(negedge clk); tach_in = 0;

    div_sel = 3; cyc(1);
    cyc(256 * step(3) + 10);
    chk("R5 saturate", period_q, 255);
    chk("R6 fault low", fault_n, 0);
    chk("R8 irq high", irq, 1);
    fault_en = 0; cyc(1);
    chk("R8 irq masked", irq, 0);
    chk("R6 fault held", fault_n, 0);
    fault_en = 1; cyc(50);
    chk("R6 fault sticky", fault_n, 0);
    fault_clr = 1; cyc(1); fault_clr = 0; cyc(1);
    chk("R9 fault cleared", fault_n, 1);
    chk("R9 irq cleared", irq, 0);
    pulse(10 * step(3));
    chk("R5 stalled window latches 255", period_q, 255);
    pulse(10 * step(3));
    chk("R5 recovery", period_q, 10);
    chk("R9 stays clear", fault_n, 1);

    fault_en = 0;
    cyc(256 * step(3) + 10);
    chk("R7 saturate masked", period_q, 255);
    chk("R7 no fault", fault_n, 1);
    chk("R7 no irq", irq, 0);
    fault_en = 1; cyc(20);
    chk("R7 late enable", fault_n, 1);

    for (int c = 0; c < 400; c++) begin
      div_sel = ((c / 10) % 2 == 1) ? 2'd2 : 2'd3;
      tach_in = (c % 40) < 20;
      @(negedge clk);
    end
    chk("R10 prescaler restart", period_q, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule